// File: doc/BRIEF.md
# Processor Free-Run Bring-Up Controller

This block replaces a host microcontroller during first power-up of an 8-bit microprocessor that has no memory attached. After a system reset it issues a fixed number of processor clock pulses with the processor reset held low, then releases reset. It feeds the no-operation opcode 0x00 onto the data bus at all times, so the processor runs straight through its address space from 0x0000. It also holds the wait, interrupt, non-maskable interrupt and bus-request inputs at their inactive high level.

Two push buttons control the processor clock. One gives a single processor clock cycle per press while clocking is stopped. The other toggles between stopped and continuous running, with a period set by a divider parameter. Both buttons pass through a two-flop synchroniser and a debounce counter.

On every processor clock after reset release, the block captures the address bus and reports it on a parallel status port, together with the data value and the position of the cycle within the four-clock fetch. A built-in checker compares the program-counter clocks against the expected linear fetch sequence. It skips the refresh clocks.

Top module: `cpu_freerun_ctrl`

## Requirements
- R1: After system reset `cpu_rst_n` is low. It rises only after exactly RESET_CYCLES complete processor clock pulses have been issued, and it stays high until the next system reset.
- R2: `cpu_data` is 0x00 at all times, and every status sample reports `stat_data` = 0x00.
- R3: `cpu_wait_n`, `cpu_int_n`, `cpu_nmi_n` and `cpu_busreq_n` are 1 at all times.
- R4: While stopped, each debounced press of `btn_step` (active high, acting on its rising edge) produces exactly one processor clock cycle: high for RUN_HALF system clocks, then low for RUN_HALF system clocks.
- R5: Each debounced press of `btn_run` toggles `run_mode` (0 after reset). While `run_mode` is 1, processor clock rising edges follow each other every 2*RUN_HALF system clocks. After it returns to 0, the cycle in progress completes and no further pulses occur.
- R6: After reset release, the block samples `cpu_addr` when `cpu_clk` falls. `stat_valid` pulses high for one system clock with `stat_addr` = the sampled address. `stat_phase` = the cycle index since release modulo 4, with 0 for the first cycle. Phases 0 and 1 are program-counter clocks; phases 2 and 3 are refresh clocks.
- R7: In phase 0 the address must be 0x0000 for the first fetch after release, and the previous phase-0 address plus one after that. In phase 1 the address must equal the phase-0 address of the same fetch. Any mismatch sets `fetch_err`, which stays 1 until system reset.
- R8: Addresses sampled in phases 2 and 3 never affect `fetch_err`.
- R9: A button level that holds for fewer than DEBOUNCE_CYCLES consecutive system clocks after synchronisation has no effect.
- R10: After reset release, no processor clock pulse occurs while stopped unless a step press arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low |
| btn_step | input | 1 | Raw single-step button, active high |
| btn_run | input | 1 | Raw run/stop toggle button, active high |
| cpu_addr | input | 16 | Processor address bus |
| cpu_clk | output | 1 | Generated processor clock |
| cpu_rst_n | output | 1 | Processor reset, active low |
| cpu_data | output | 8 | Forced data bus value (0x00) |
| cpu_wait_n | output | 1 | Wait input, held inactive |
| cpu_int_n | output | 1 | Interrupt input, held inactive |
| cpu_nmi_n | output | 1 | Non-maskable interrupt input, held inactive |
| cpu_busreq_n | output | 1 | Bus request input, held inactive |
| run_mode | output | 1 | 1 while continuous clocking is selected |
| stat_valid | output | 1 | One-clock strobe for a new status sample |
| stat_addr | output | 16 | Sampled address bus |
| stat_data | output | 8 | Sampled data bus |
| stat_phase | output | 2 | Clock position within the fetch (0..3) |
| fetch_err | output | 1 | Sticky fetch-sequence mismatch flag |

## Verification
The bench builds the block with RESET_CYCLES=5, RUN_HALF=2 and DEBOUNCE_CYCLES=4. A reset length above the minimum of three shows that the pulse count follows the parameter. A short divider lets many four-clock fetches pass in a short run. A four-cycle debounce window lets a three-cycle glitch be shown to be rejected beside a real press. A processor stub can corrupt a chosen program-counter clock, so each checker rule is triggered on its own.

// File: rtl/cpu_freerun_ctrl.sv
`timescale 1ns/1ps
module cpu_freerun_ctrl #(
  parameter int RESET_CYCLES    = 3,
  parameter int RUN_HALF        = 4,
  parameter int DEBOUNCE_CYCLES = 20000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        btn_step,
  input  logic        btn_run,
  input  logic [15:0] cpu_addr,
  output logic        cpu_clk,
  output logic        cpu_rst_n,
  output logic [7:0]  cpu_data,
  output logic        cpu_wait_n,
  output logic        cpu_int_n,
  output logic        cpu_nmi_n,
  output logic        cpu_busreq_n,
  output logic        run_mode,
  output logic        stat_valid,
  output logic [15:0] stat_addr,
  output logic [7:0]  stat_data,
  output logic [1:0]  stat_phase,
  output logic        fetch_err
);
  localparam int DW = $clog2(DEBOUNCE_CYCLES + 1);
  localparam int HW = $clog2(RUN_HALF + 1);
  localparam int RW = $clog2(RESET_CYCLES + 1);

  assign cpu_data     = 8'h00;
  assign cpu_wait_n   = 1'b1;
  assign cpu_int_n    = 1'b1;
  assign cpu_nmi_n    = 1'b1;
  assign cpu_busreq_n = 1'b1;

  logic [1:0] btn_raw, ev;
  assign btn_raw = {btn_run, btn_step};

  for (genvar i = 0; i < 2; i++) begin : g_deb
    logic s1, s2, stb, stb_d;
    logic [DW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0; s2 <= 1'b0; stb <= 1'b0; stb_d <= 1'b0; cnt <= '0;
      end else begin
        s1 <= btn_raw[i];
        s2 <= s1;
        stb_d <= stb;
        if (s2 == stb) cnt <= '0;
        else if (cnt == DW'(DEBOUNCE_CYCLES - 1)) begin
          stb <= s2;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
      end
    end
    assign ev[i] = stb & ~stb_d;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run_mode <= 1'b0;
    else if (ev[1]) run_mode <= ~run_mode;

  typedef enum logic [1:0] {PH_IDLE, PH_HI, PH_LO} ph_t;
  ph_t ph;
  logic [HW-1:0] hcnt;
  logic [RW-1:0] rcnt;
  logic smp;

  assign smp = (ph == PH_HI) && (hcnt == '0) && cpu_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; hcnt <= '0; rcnt <= '0;
      cpu_clk <= 1'b0; cpu_rst_n <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE:
          if (!cpu_rst_n || run_mode || ev[0]) begin
            ph <= PH_HI; cpu_clk <= 1'b1; hcnt <= HW'(RUN_HALF - 1);
          end
        PH_HI:
          if (hcnt == '0) begin
            ph <= PH_LO; cpu_clk <= 1'b0; hcnt <= HW'(RUN_HALF - 1);
          end else hcnt <= hcnt - 1'b1;
        PH_LO:
          if (hcnt != '0) hcnt <= hcnt - 1'b1;
          else if (!cpu_rst_n && rcnt == RW'(RESET_CYCLES - 1)) begin
            cpu_rst_n <= 1'b1; ph <= PH_IDLE;
          end else if (!cpu_rst_n || run_mode) begin
            if (!cpu_rst_n) rcnt <= rcnt + 1'b1;
            ph <= PH_HI; cpu_clk <= 1'b1; hcnt <= HW'(RUN_HALF - 1);
          end else ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  logic [15:0] last_fetch;
  logic        seen;
  logic [1:0]  cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid <= 1'b0; stat_addr <= '0; stat_data <= '0; stat_phase <= '0;
      cyc <= '0; last_fetch <= '0; seen <= 1'b0; fetch_err <= 1'b0;
    end else begin
      stat_valid <= smp;
      if (smp) begin
        stat_addr  <= cpu_addr;
        stat_data  <= cpu_data;
        stat_phase <= cyc;
        cyc        <= cyc + 1'b1;
        if (cyc == 2'd0) begin
          if (cpu_addr != (seen ? last_fetch + 16'd1 : 16'h0000)) fetch_err <= 1'b1;
          last_fetch <= cpu_addr;
          seen       <= 1'b1;
        end else if (cyc == 2'd1) begin
          if (cpu_addr != last_fetch) fetch_err <= 1'b1;
        end
      end
    end
  end

  logic          clk_d;
  logic [RW:0]   a_falls;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d <= 1'b0; a_falls <= '0;
    end else begin
      clk_d <= cpu_clk;
      if (!cpu_rst_n && clk_d && !cpu_clk && a_falls != '1) a_falls <= a_falls + 1'b1;
    end
  end

  assert_reset_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> (a_falls == (RW+1)'(RESET_CYCLES)));
  assert_reset_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n |=> cpu_rst_n);
  assert_step_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst_n && !run_mode && !$past(run_mode) && $rose(cpu_clk)) |-> $past(ev[0]));
  assert_sample_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> ($fell(cpu_clk) && cpu_rst_n));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err |=> fetch_err);
endmodule

// File: tb/cpu_freerun_ctrl_bench.sv
`timescale 1ns/1ps
module cpu_freerun_ctrl_bench;
  localparam int RC = 5, HALF = 2, DEB = 4;

  logic clk = 1'b0, rst_n = 1'b0, btn_step = 1'b0, btn_run = 1'b0;
  logic [15:0] cpu_addr;
  logic cpu_clk, cpu_rst_n, cpu_wait_n, cpu_int_n, cpu_nmi_n, cpu_busreq_n;
  logic run_mode, stat_valid, fetch_err;
  logic [7:0] cpu_data, stat_data;
  logic [15:0] stat_addr;
  logic [1:0] stat_phase;

  cpu_freerun_ctrl #(.RESET_CYCLES(RC), .RUN_HALF(HALF), .DEBOUNCE_CYCLES(DEB)) u_cpu_freerun_ctrl (
    .clk(clk), .rst_n(rst_n), .btn_step(btn_step), .btn_run(btn_run), .cpu_addr(cpu_addr),
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cpu_data(cpu_data), .cpu_wait_n(cpu_wait_n),
    .cpu_int_n(cpu_int_n), .cpu_nmi_n(cpu_nmi_n), .cpu_busreq_n(cpu_busreq_n),
    .run_mode(run_mode), .stat_valid(stat_valid), .stat_addr(stat_addr),
    .stat_data(stat_data), .stat_phase(stat_phase), .fetch_err(fetch_err));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int rises = 0, rst_falls = 0;
  logic [15:0] sk = '0;
  logic bad0 = 1'b0, bad1 = 1'b0;

  function automatic logic [15:0] model(input logic [15:0] k);
    logic [15:0] a;
    a = (k[1] == 1'b0) ? (k >> 2) : (16'h8000 | k);
    if (k[1:0] == 2'd0 && bad0) a = a + 16'h0010;
    if (k[1:0] == 2'd1 && bad1) a = a ^ 16'h0001;
    return a;
  endfunction

  always @(posedge cpu_clk) begin
    if (!cpu_rst_n) begin sk <= '0; cpu_addr <= 16'hBEEF; end
    else begin cpu_addr <= model(sk); sk <= sk + 16'd1; end
  end
  initial cpu_addr = 16'hBEEF;
  always @(posedge cpu_clk) rises++;
  always @(negedge cpu_clk) if (!cpu_rst_n) rst_falls++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press_step();
    btn_step = 1'b1; waitc(DEB + 8);
    btn_step = 1'b0; waitc(DEB + 8);
  endtask

  task automatic press_run();
    btn_run = 1'b1; waitc(DEB + 8);
    btn_run = 1'b0; waitc(DEB + 8);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bad0 = 1'b0; bad1 = 1'b0; waitc(4);
    rst_falls = 0;
    rst_n = 1'b1; waitc(2 * HALF * RC + 20);
  endtask

  localparam logic [31:0] VEC [6] = '{
    {8'd1, 16'h0000, 8'd0},
    {8'd1, 16'h0000, 8'd1},
    {8'd1, 16'h8002, 8'd2},
    {8'd2, 16'h0001, 8'd0},
    {8'd3, 16'h8007, 8'd3},
    {8'd1, 16'h0002, 8'd0}
  };

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int r0, tstart;
    time t1, t2;
    waitc(3);
    chk("R1 reset held low", cpu_rst_n, 0);
    chk("R2 data bus", cpu_data, 8'h00);
    chk("R3 control pins", {cpu_wait_n, cpu_int_n, cpu_nmi_n, cpu_busreq_n}, 4'hF);
    chk("R5 run_mode after reset", run_mode, 0);
    rst_n = 1'b1;
    waitc(2 * HALF * RC + 20);
    chk("R1 reset released", cpu_rst_n, 1);
    chk("R1 pulses during reset", rst_falls, RC);

    r0 = rises; waitc(40);
    chk("R10 no pulses while stopped", rises, r0);

    btn_step = 1'b1; waitc(3); btn_step = 1'b0; waitc(30);
    chk("R9 glitch ignored", rises, r0);

    foreach (VEC[i]) begin
      r0 = rises;
      for (int s = 0; s < VEC[i][31:24]; s++) press_step();
      chk("R4 one cycle per press", rises - r0, VEC[i][31:24]);
      chk("R6 sampled address", stat_addr, VEC[i][23:8]);
      chk("R6 sample phase", stat_phase, VEC[i][1:0]);
      chk("R2 sampled data", stat_data, 8'h00);
    end
    chk("R7 no error on clean stepping", fetch_err, 0);

    press_run();
    chk("R5 run toggled on", run_mode, 1);
    @(posedge cpu_clk); t1 = $time;
    @(posedge cpu_clk); t2 = $time;
    chk("R5 run period", 32'(t2 - t1), 32'(2 * HALF * 20));
    tstart = 0;
    while (tstart < 200) begin
      @(negedge clk);
      if (stat_valid) tstart++;
    end
    press_run();
    chk("R5 run toggled off", run_mode, 0);
    waitc(10);
    r0 = rises; waitc(60);
    chk("R5 stopped after toggle", rises, r0);
    chk("R8 refresh addresses ignored", fetch_err, 0);

    r0 = int'(sk);
    press_step();
    chk("R6 address after run", stat_addr, model(16'(r0)));
    chk("R6 phase after run", stat_phase, 32'(r0 % 4));

    do_reset();
    chk("R1 reset again", cpu_rst_n, 1);
    bad0 = 1'b1;
    for (int s = 0; s < 4; s++) press_step();
    bad0 = 1'b0;
    chk("R7 bad fetch step flagged", fetch_err, 1);
    press_step();
    chk("R7 error sticky", fetch_err, 1);

    do_reset();
    chk("R7 cleared by reset", fetch_err, 0);
    bad1 = 1'b1;
    for (int s = 0; s < 4; s++) press_step();
    bad1 = 1'b0;
    chk("R7 second clock mismatch flagged", fetch_err, 1);

    finish_run();
  end
endmodule